// File: doc/BRIEF.md
# Framed 24-bit serial command receiver

This block takes command words from a write-only three-wire serial link: an active-low frame line, a serial clock and a data line. The block runs on a faster system clock, well above the serial rate. It passes all three wires through two-flop synchronizers and finds their edges inside the system clock domain. While a frame is open, each falling serial-clock edge shifts one data bit in, most significant bit first.

A frame is exactly 24 bits. On the 24th falling edge the word is handed on, with a single-cycle valid strobe, without waiting for the frame line to return high. Any serial-clock activity after that is ignored until the frame line falls again.

If the frame line rises before the 24th bit, the partial frame is dropped. The output word is left as it was, and a one-cycle abort pulse reports the discarded frame. The system clock must run at least four times faster than the serial clock.

Top module: `sfr_rx`

## Requirements
- R1: While reset is asserted, and until the first complete frame, `word_o` is 0 and both `word_valid_o` and `abort_o` are low.
- R2: A falling edge of `ser_frame_n` opens a frame. Each later falling edge of `ser_clk` samples `ser_data`, and the first bit sampled lands in bit 23 of `word_o`.
- R3: Each complete frame raises `word_valid_o` for exactly one system clock cycle, in the same cycle that the new `word_o` value appears.
- R4: The word is delivered after the 24th falling serial-clock edge even if `ser_frame_n` is still low.
- R5: Serial-clock edges after the 24th, while `ser_frame_n` stays low, change neither `word_o` nor `word_valid_o`.
- R6: A rise of `ser_frame_n` before the 24th falling edge gives no valid strobe and leaves `word_o` unchanged. It raises `abort_o` for one cycle, and `abort_o` is never high in the same cycle as `word_valid_o`.
- R7: A rise of `ser_frame_n` after a completed frame raises no abort.
- R8: A new frame starts only on the next falling edge of `ser_frame_n`. Frames separated by a short high pulse on that line are each received in full.
- R9: Serial-clock edges while `ser_frame_n` is high capture nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_frame_n | input | 1 | Active-low frame line; its falling edge opens a frame |
| ser_clk | input | 1 | Serial clock; data is sampled on its falling edges |
| ser_data | input | 1 | Serial data, most significant bit first |
| word_o | output | 24 | Last completed command word |
| word_valid_o | output | 1 | One-cycle strobe marking a newly completed word |
| abort_o | output | 1 | One-cycle pulse marking a discarded partial frame |

## Verification
The bench sends frames cut short at 1, 10 and 23 bits. A receiver that committed a partial word would change `word_o` or strobe valid on these frames. It also sends frames carrying 30 and 48 clocks. A receiver that kept shifting after bit 24 would corrupt the word or emit a second strobe.

Delivery is checked while the frame line is still low, which catches a design that waits for the line to rise. Other stimuli are serial-clock toggles while the line is high, and two frames separated by a frame-line pulse only two system cycles long. These catch stray capture and a missed restart.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  // bit positions inside the edge-detector vector
  localparam int LINE_SCLK  = 0;
  localparam int LINE_FRAME = 1;
  localparam int EDGE_LINES = 2;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int                 WIDTH   = 3,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge #(
  parameter int               WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o,
  output logic [WIDTH-1:0] rise_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
  assign rise_o = ~prev_q & lvl_i;
endmodule

// File: rtl/sfr_frame.sv
module sfr_frame #(
  parameter int FRAME_BITS = 24,
  localparam int CNT_W     = $clog2(FRAME_BITS),
  localparam int LAST      = FRAME_BITS - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frame_fall_i,
  input  logic                  frame_rise_i,
  input  logic                  sclk_fall_i,
  input  logic                  sclk_rise_i,
  input  logic                  data_i,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  valid_o,
  output logic                  abort_o
);
  logic                  active_q, active_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [FRAME_BITS-1:0] word_q, word_d;
  logic                  valid_q, valid_d;
  logic                  abort_q, abort_d;
  logic                  shift_en, word_en;

  assign shift_en = active_q && sclk_fall_i && !frame_fall_i && !frame_rise_i;
  assign word_en  = shift_en && (cnt_q == CNT_W'(LAST));

  // next-state logic
  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    word_d   = word_q;
    valid_d  = 1'b0;
    abort_d  = 1'b0;
    if (frame_fall_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sh_d     = '0;
    end else if (frame_rise_i) begin
      abort_d  = active_q;
      active_d = 1'b0;
      cnt_d    = '0;
      sh_d     = '0;
    end else if (shift_en) begin
      sh_d = {sh_q[FRAME_BITS-2:0], data_i};
      if (word_en) begin
        word_d   = {sh_q[FRAME_BITS-2:0], data_i};
        valid_d  = 1'b1;
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      valid_q  <= 1'b0;
      abort_q  <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      valid_q  <= valid_d;
      abort_q  <= abort_d;
    end
  end

  // word register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign abort_o = abort_q;

  // R2
  bit_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LAST));

  // R2
  rise_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise_i && !frame_fall_i && !frame_rise_i) |=> $stable(cnt_q));

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R6
  abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> $past(active_q));

  // R6
  not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && abort_q));
endmodule

// File: rtl/sfr_rx.sv
module sfr_rx #(
  parameter int FRAME_BITS  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_frame_n,
  input  logic                  ser_clk,
  input  logic                  ser_data,
  output logic [FRAME_BITS-1:0] word_o,
  output logic                  word_valid_o,
  output logic                  abort_o
);
  import sfr_pkg::*;

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [2:0]            raw_in, syn_in;
  logic [EDGE_LINES-1:0] edge_lvl, edge_fall, edge_rise;

  assign raw_in = {ser_frame_n, ser_clk, ser_data};

  sfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .d_i  (raw_in),
    .q_o  (syn_in)
  );

  assign edge_lvl[LINE_FRAME] = syn_in[2];
  assign edge_lvl[LINE_SCLK]  = syn_in[1];

  sfr_edge #(.WIDTH(EDGE_LINES), .RST_VAL(2'b10)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl_i (edge_lvl),
    .fall_o(edge_fall),
    .rise_o(edge_rise)
  );

  sfr_frame #(.FRAME_BITS(FRAME_BITS)) u_frame (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_fall_i(edge_fall[LINE_FRAME]),
    .frame_rise_i(edge_rise[LINE_FRAME]),
    .sclk_fall_i (edge_fall[LINE_SCLK]),
    .sclk_rise_i (edge_rise[LINE_SCLK]),
    .data_i      (syn_in[0]),
    .word_o      (word_o),
    .valid_o     (word_valid_o),
    .abort_o     (abort_o)
  );

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(word_o) |-> word_valid_o);
endmodule

// File: tb/sfr_rx_test.sv
module sfr_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_frame_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_data = 1'b0;
  logic [23:0] word_o;
  logic        word_valid_o;
  logic        abort_o;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  int acnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  sfr_rx uut (
    .clk(clk), .rst_n(rst_n), .ser_frame_n(ser_frame_n),
    .ser_clk(ser_clk), .ser_data(ser_data),
    .word_o(word_o), .word_valid_o(word_valid_o), .abort_o(abort_o)
  );

  always @(negedge clk) begin
    if (word_valid_o) vcnt++;
    if (abort_o)      acnt++;
  end

  // {word, bit count}
  localparam logic [29:0] VECS [9] = '{
    {24'hA5C3F0, 6'd24},
    {24'h000001, 6'd24},
    {24'h800000, 6'd24},
    {24'h123456, 6'd10},
    {24'hFFFFFF, 6'd24},
    {24'h0F0F0F, 6'd30},
    {24'hABCDEF, 6'd1},
    {24'h5A5A5A, 6'd23},
    {24'hFEDCBA, 6'd48}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [23:0] w, input int nb);
    for (int i = 0; i < nb; i++) begin
      ser_data = (i < 24) ? w[23-i] : i[0];
      wait_clk(4);
      ser_clk = 1'b0;
      wait_clk(4);
      ser_clk = 1'b1;
    end
  endtask

  initial begin
    logic [23:0] exp_word;
    int v0, a0;
    exp_word = '0;
    wait_clk(3);
    // R1: outputs during reset
    chk("R1 word in reset", word_o, 0);
    chk("R1 valid in reset", word_valid_o, 0);
    chk("R1 abort in reset", abort_o, 0);
    rst_n = 1'b1;
    wait_clk(8);
    chk("R1 word after reset", word_o, 0);

    for (int i = 0; i < 9; i++) begin
      logic [23:0] w;
      int nb;
      w  = VECS[i][29:6];
      nb = int'(VECS[i][5:0]);
      v0 = vcnt; a0 = acnt;
      ser_frame_n = 1'b0;
      wait_clk(4);
      send_bits(w, nb);
      wait_clk(8);
      if (nb >= 24) begin
        exp_word = w;
        // R4: delivered while frame line still low
        chk("R4 valid before frame rise", vcnt - v0, 1);
        // R2: MSB-first word
        chk("R2 word content", word_o, exp_word);
      end
      ser_frame_n = 1'b1;
      wait_clk(8);
      // R3 / R5: one strobe per complete frame, none extra
      chk("R3 R5 valid count", vcnt - v0, (nb >= 24) ? 1 : 0);
      // R6 / R7: abort only on a short frame
      chk("R6 R7 abort count", acnt - a0, (nb >= 24) ? 0 : 1);
      chk("R5 R6 word held", word_o, exp_word);
    end

    // R9: serial clocks while frame line high
    v0 = vcnt; a0 = acnt;
    send_bits(24'h3C3C3C, 24);
    wait_clk(8);
    chk("R9 no valid while idle", vcnt - v0, 0);
    chk("R9 no abort while idle", acnt - a0, 0);
    chk("R9 word unchanged", word_o, exp_word);
    ser_frame_n = 1'b0;
    wait_clk(4);
    send_bits(24'hC3A5E1, 24);
    ser_frame_n = 1'b1;
    wait_clk(8);
    chk("R9 clean frame after idle clocks", word_o, 24'hC3A5E1);

    // R8: back-to-back frames, short high gap
    v0 = vcnt; a0 = acnt;
    ser_frame_n = 1'b0;
    wait_clk(4);
    send_bits(24'h135790, 24);
    wait_clk(8);
    chk("R8 first word", word_o, 24'h135790);
    ser_frame_n = 1'b1;
    wait_clk(2);
    ser_frame_n = 1'b0;
    wait_clk(4);
    send_bits(24'h2468AC, 24);
    wait_clk(8);
    chk("R8 second word", word_o, 24'h2468AC);
    chk("R8 two strobes", vcnt - v0, 2);
    ser_frame_n = 1'b1;
    wait_clk(8);
    chk("R7 no abort after full frames", acnt - a0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule